// File: doc/BRIEF.md
# Descriptor ring copy source engine

This block is the sending half of a host-to-target copy engine. Software builds a ring of descriptors in memory, each naming a buffer address, a byte count, a transfer id and two option bits, then publishes them by moving a write index held in a small register file. The engine walks the ring from its own read index, fetches each descriptor and then the buffer it names over a single-outstanding memory read port, and sends the buffer contents out on a 32-bit byte stream with byte-lane enables.

A descriptor marked as gather is joined to the descriptors that follow it. The chain ends at the first descriptor without the mark, and the whole chain leaves as one packet with one end marker and one completion pulse. The read index moves forward after every descriptor, chained or not, so software can poll it to reclaim slots. A byte count of zero or above the programmed limit stops the engine until reset.

Top module: `copy_src_engine`

## Requirements
- R1: After reset the read and write indices read 0, the stream is not valid, no memory request is made, and the completion and error outputs are low.
- R2: The engine stays idle while the read index equals the write index. After a register write makes them differ, the memory request stays low in the following cycle and rises in the cycle after that.
- R3: Descriptor i sits at ring base + 8*i. The word at offset 0 is the buffer address. In the word at offset 4, bits [15:0] are the byte count, bit 16 is gather, bit 17 is byte swap and bits [31:20] are the transfer id.
- R4: A descriptor of n bytes produces ceil(n/4) beats, read from consecutive words starting at the buffer address with its two low bits cleared. Byte k of each word is in lane k, and tkeep enables the lowest min(4, remaining) lanes.
- R5: When the descriptor's swap bit or the control register's ring-swap bit (bit 16) is set, the bytes of each 32-bit beat are reversed.
- R6: A run of gather descriptors plus the closing descriptor forms one packet. Each descriptor starts a fresh beat, and tlast is high only on the final beat of the closing descriptor.
- R7: done_o pulses for exactly one cycle, in the cycle after the handshake of a tlast beat. m_tid_o carries the transfer id of the descriptor being streamed, so at tlast it is the id of the closing descriptor.
- R8: The read index becomes (index + 1) & (size - 1) at the clock edge of each descriptor's final beat handshake, and at no other time.
- R9: A byte count of 0 or above the control register's limit (bits [15:0]) sets err_o and halts the engine. In that case nothing is streamed and the read index does not move until reset. A count equal to the limit is accepted.
- R10: Register map: 0 ring base, 1 ring size (must be a power of two), 2 write index, 3 read index (read-only, writes ignored), 4 control, 5 status (bit 0 halted). A written write index is stored masked with size - 1.
- R11: While tvalid is high and tready is low, tvalid, tdata, tkeep and tlast hold their values.
- R12: A memory request holds, with a stable address, until mem_rvalid_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory byte address |
| mem_rvalid_i | input | 1 | Read data valid, ends the request |
| mem_rdata_i | input | DW | Read data |
| m_tvalid_o | output | 1 | Stream beat valid |
| m_tready_i | input | 1 | Stream sink ready |
| m_tdata_o | output | DW | Stream data |
| m_tkeep_o | output | DW/8 | Byte-lane enables |
| m_tlast_o | output | 1 | Final beat of a packet |
| m_tid_o | output | TID_W | Transfer id of the current descriptor |
| done_o | output | 1 | One-cycle completion pulse per packet |
| err_o | output | 1 | Descriptor length error, engine halted |

## Verification
A read index that drifts shows up in two ways. Register 3 gives a wrong value in the very cycle after the bad edge, and the next descriptor fetch goes to the wrong address, which shows as wrong stream data within a few cycles. A lost or stray gather flag shows as tlast and done_o appearing on the wrong beat, or on no beat at all, at the end of the packet. The bench compares every beat, every done_o cycle and the read index against a queue model on each clock. A length check that misfires shows up at once: it either halts the engine on a valid descriptor or lets an oversized one stream.

// File: rtl/ce_src_pkg.sv
package ce_src_pkg;
  localparam int unsigned DESC_SHIFT = 3;   // 8-byte descriptors
  localparam int unsigned FLG_GATHER = 16;
  localparam int unsigned FLG_SWAP   = 17;
  localparam int unsigned TID_LSB    = 20;
  localparam int unsigned CTRL_SWAP  = 16;

  typedef enum logic [2:0] {
    RA_BASE = 3'd0, RA_SIZE = 3'd1, RA_WIDX = 3'd2,
    RA_RIDX = 3'd3, RA_CTRL = 3'd4, RA_STAT = 3'd5
  } reg_addr_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_LEN, ST_DREQ, ST_DOUT, ST_HALT
  } xfer_st_e;
endpackage

// File: rtl/ce_src_swap.sv
module ce_src_swap #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] data_i,
  input  logic          en_i,
  output logic [DW-1:0] data_o
);
  localparam int unsigned NB = DW / 8;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign data_o[8*i +: 8] = en_i ? data_i[8*(NB-1-i) +: 8] : data_i[8*i +: 8];
  end
endmodule

// File: rtl/ce_src_regs.sv
module ce_src_regs import ce_src_pkg::*; #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [31:0]      wdata_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             halted_i,
  output logic [AW-1:0]    base_o,
  output logic [IDX_W-1:0] mask_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [LEN_W-1:0] max_len_o,
  output logic             ring_swap_o,
  output logic [31:0]      rdata_o
);
  logic [IDX_W:0] size_q;

  assign mask_o = IDX_W'(size_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o      <= '0;
      size_q      <= (IDX_W+1)'(1) << IDX_W;
      wr_idx_o    <= '0;
      max_len_o   <= '1;
      ring_swap_o <= 1'b0;
    end else if (we_i) begin
      case (reg_addr_e'(addr_i))
        RA_BASE: base_o   <= AW'(wdata_i);
        RA_SIZE: size_q   <= wdata_i[IDX_W:0];
        RA_WIDX: wr_idx_o <= wdata_i[IDX_W-1:0] & mask_o;
        RA_CTRL: begin
          max_len_o   <= wdata_i[LEN_W-1:0];
          ring_swap_o <= wdata_i[CTRL_SWAP];
        end
        default: ;  // read index and status are read-only
      endcase
    end
  end

  always_comb begin
    case (reg_addr_e'(addr_i))
      RA_BASE: rdata_o = 32'(base_o);
      RA_SIZE: rdata_o = 32'(size_q);
      RA_WIDX: rdata_o = 32'(wr_idx_o);
      RA_RIDX: rdata_o = 32'(rd_idx_i);
      RA_CTRL: rdata_o = 32'(max_len_o) | (32'(ring_swap_o) << CTRL_SWAP);
      RA_STAT: rdata_o = 32'(halted_i);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ce_src_xfer.sv
module ce_src_xfer import ce_src_pkg::*; #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned TID_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    base_i,
  input  logic [IDX_W-1:0] mask_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [LEN_W-1:0] max_len_i,
  input  logic             ring_swap_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             m_tvalid_o,
  input  logic             m_tready_i,
  output logic [DW-1:0]    m_tdata_o,
  output logic [DW/8-1:0]  m_tkeep_o,
  output logic             m_tlast_o,
  output logic [TID_W-1:0] m_tid_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int unsigned NB = DW / 8;

  xfer_st_e         st_q;
  logic [AW-1:0]    buf_q;
  logic [LEN_W-1:0] rem_q;
  logic             gat_q, swp_q, done_q;
  logic [TID_W-1:0] tid_q;
  logic [DW-1:0]    dat_q;

  logic [AW-1:0]    desc_addr;
  logic [LEN_W-1:0] new_len;
  logic             len_bad, last_beat;

  assign desc_addr = base_i + (AW'(rd_idx_o) << DESC_SHIFT);
  assign new_len   = mem_rdata_i[LEN_W-1:0];
  assign len_bad   = (new_len == '0) || (new_len > max_len_i);
  assign last_beat = rem_q <= LEN_W'(NB);

  always_comb begin
    mem_req_o  = 1'b1;
    mem_addr_o = '0;
    case (st_q)
      ST_ADDR: mem_addr_o = desc_addr;
      ST_LEN:  mem_addr_o = desc_addr + AW'(4);
      ST_DREQ: mem_addr_o = buf_q & ~AW'(NB - 1);
      default: mem_req_o  = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      rd_idx_o <= '0;
      buf_q    <= '0;
      rem_q    <= '0;
      gat_q    <= 1'b0;
      swp_q    <= 1'b0;
      tid_q    <= '0;
      dat_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (rd_idx_o != wr_idx_i) st_q <= ST_ADDR;
        ST_ADDR: if (mem_rvalid_i) begin
          buf_q <= AW'(mem_rdata_i);
          st_q  <= ST_LEN;
        end
        ST_LEN: if (mem_rvalid_i) begin
          rem_q <= new_len;
          gat_q <= mem_rdata_i[FLG_GATHER];
          swp_q <= mem_rdata_i[FLG_SWAP];
          tid_q <= mem_rdata_i[TID_LSB +: TID_W];
          st_q  <= len_bad ? ST_HALT : ST_DREQ;
        end
        ST_DREQ: if (mem_rvalid_i) begin
          dat_q <= mem_rdata_i;
          st_q  <= ST_DOUT;
        end
        ST_DOUT: if (m_tready_i) begin
          if (last_beat) begin
            rd_idx_o <= (rd_idx_o + 1'b1) & mask_i;
            done_q   <= !gat_q;
            st_q     <= ST_IDLE;
          end else begin
            rem_q <= rem_q - LEN_W'(NB);
            buf_q <= buf_q + AW'(NB);
            st_q  <= ST_DREQ;
          end
        end
        default: ;  // ST_HALT holds until reset
      endcase
    end
  end

  assign m_tvalid_o = st_q == ST_DOUT;
  assign m_tlast_o  = last_beat && !gat_q;
  assign m_tid_o    = tid_q;
  assign done_o     = done_q;
  assign err_o      = st_q == ST_HALT;

  for (genvar i = 0; i < NB; i++) begin : g_keep
    assign m_tkeep_o[i] = rem_q > LEN_W'(i);
  end

  ce_src_swap #(.DW(DW)) u_swap (
    .data_i (dat_q),
    .en_i   (swp_q | ring_swap_i),
    .data_o (m_tdata_o)
  );
endmodule

// File: rtl/copy_src_engine.sv
module copy_src_engine #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned TID_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             m_tvalid_o,
  input  logic             m_tready_i,
  output logic [DW-1:0]    m_tdata_o,
  output logic [DW/8-1:0]  m_tkeep_o,
  output logic             m_tlast_o,
  output logic [TID_W-1:0] m_tid_o,
  output logic             done_o,
  output logic             err_o
);
  logic [AW-1:0]    ring_base;
  logic [IDX_W-1:0] ring_mask, wr_idx, rd_idx;
  logic [LEN_W-1:0] max_len;
  logic             ring_swap;

  ce_src_regs #(.IDX_W(IDX_W), .AW(AW), .LEN_W(LEN_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rd_idx_i    (rd_idx),
    .halted_i    (err_o),
    .base_o      (ring_base),
    .mask_o      (ring_mask),
    .wr_idx_o    (wr_idx),
    .max_len_o   (max_len),
    .ring_swap_o (ring_swap),
    .rdata_o     (reg_rdata_o)
  );

  ce_src_xfer #(.IDX_W(IDX_W), .AW(AW), .DW(DW), .LEN_W(LEN_W), .TID_W(TID_W)) u_xfer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .base_i       (ring_base),
    .mask_i       (ring_mask),
    .wr_idx_i     (wr_idx),
    .max_len_i    (max_len),
    .ring_swap_i  (ring_swap),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .m_tvalid_o   (m_tvalid_o),
    .m_tready_i   (m_tready_i),
    .m_tdata_o    (m_tdata_o),
    .m_tkeep_o    (m_tkeep_o),
    .m_tlast_o    (m_tlast_o),
    .m_tid_o      (m_tid_o),
    .rd_idx_o     (rd_idx),
    .done_o       (done_o),
    .err_o        (err_o)
  );
endmodule

// File: rtl/ce_src_checker.sv
module ce_src_checker #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             m_tvalid_i,
  input logic             m_tready_i,
  input logic [DW-1:0]    m_tdata_i,
  input logic [DW/8-1:0]  m_tkeep_i,
  input logic             m_tlast_i,
  input logic             done_i,
  input logic             err_i,
  input logic             mem_req_i,
  input logic             mem_rvalid_i,
  input logic [AW-1:0]    mem_addr_i,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic [IDX_W-1:0] mask_i
);
  a_r11_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_i && !m_tready_i |=> m_tvalid_i && $stable(m_tdata_i) && $stable(m_tkeep_i)
                                  && $stable(m_tlast_i));

  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_rvalid_i |=> mem_req_i && $stable(mem_addr_i));

  a_r9_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_i && !m_tvalid_i);

  a_r7_done_follows_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(m_tvalid_i && m_tready_i && m_tlast_i));

  a_r8_index_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_i != $past(rd_idx_i) |->
      rd_idx_i == IDX_W'(($past(rd_idx_i) + 1'b1) & mask_i) && $past(m_tvalid_i && m_tready_i));

  a_r4_keep_low_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_i |-> m_tkeep_i != '0 && ((DW/8)'(m_tkeep_i + 1'b1) & m_tkeep_i) == '0);
endmodule

bind copy_src_engine ce_src_checker #(.IDX_W(IDX_W), .AW(AW), .DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .m_tvalid_i   (m_tvalid_o),
  .m_tready_i   (m_tready_i),
  .m_tdata_i    (m_tdata_o),
  .m_tkeep_i    (m_tkeep_o),
  .m_tlast_i    (m_tlast_o),
  .done_i       (done_o),
  .err_i        (err_o),
  .mem_req_i    (mem_req_o),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_addr_i   (mem_addr_o),
  .rd_idx_i     (rd_idx),
  .mask_i       (ring_mask)
);

// File: tb/copy_src_engine_bench.sv
module copy_src_engine_bench;
  localparam int BASE = 32'h100;
  localparam int MAXL = 64;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd3;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        tvalid, tready = 1'b1, tlast, done, err;
  logic [31:0] tdata;
  logic [3:0]  tkeep;
  logic [11:0] tid;

  logic [31:0] mem [0:2047];
  logic stall = 1'b0, stall_en = 1'b0, rdy_mode = 1'b0;
  int cyc = 0;

  assign mem_rvalid = mem_req && !stall;
  assign mem_rdata  = mem[mem_addr[12:2]];

  copy_src_engine u_copy_src_engine (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .m_tvalid_o(tvalid), .m_tready_i(tready), .m_tdata_o(tdata), .m_tkeep_o(tkeep),
    .m_tlast_o(tlast), .m_tid_o(tid), .done_o(done), .err_o(err)
  );

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [49:0] exp_q [$];   // {desc_final, tid, last, keep, data}
  int  rd_exp = 0, ring_sz = 256, bufptr = 32'h400, done_seen = 0;
  bit  ring_swap_b = 0, mon_en = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tready = !rdy_mode || (cyc % 4 != 0);
    stall  = stall_en && (cyc % 3 == 1);
  end

  // queue-based reference model, compared every clock
  initial begin
    bit prev_last = 0, prev_stall = 0, prev_req = 0;
    logic [31:0] p_data = '0, p_addr = '0;
    logic [3:0]  p_keep = '0;
    logic        p_last = 0;
    forever begin
      @(negedge clk); #4;
      if (!rst_ni || !mon_en) begin
        prev_last = 0; prev_stall = 0; prev_req = 0;
      end else begin
        chk(done == prev_last, "R7 done pulse timing", done, prev_last);
        if (done) done_seen++;
        if (prev_stall)
          chk(tvalid && tdata == p_data && tkeep == p_keep && tlast == p_last,
              "R11 stalled beat held", {tvalid, tdata}, {1'b1, p_data});
        if (prev_req)
          chk(mem_req && mem_addr == p_addr, "R12 request held", mem_addr, p_addr);
        if (reg_addr == 3'd3 && !reg_we)
          chk(reg_rdata == 32'(rd_exp), "R8 read index", reg_rdata, rd_exp);
        prev_stall = tvalid && !tready;
        p_data = tdata; p_keep = tkeep; p_last = tlast;
        prev_req = mem_req && !mem_rvalid; p_addr = mem_addr;
        prev_last = 0;
        if (tvalid && tready) begin
          if (exp_q.size() == 0) begin
            chk(0, "R9 unexpected beat", tdata, 0);
          end else begin
            logic [49:0] e;
            e = exp_q.pop_front();
            chk(tdata == e[31:0], "R4/R5 beat data", tdata, e[31:0]);
            chk(tkeep == e[35:32], "R4 tkeep", tkeep, e[35:32]);
            chk(tlast == e[36], "R6 tlast", tlast, e[36]);
            chk(tid == e[48:37], "R7 transfer id", tid, e[48:37]);
            if (e[49]) rd_exp = (rd_exp + 1) & (ring_sz - 1);
          end
          prev_last = tlast;
        end
      end
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_addr = 3'd3;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata; #1 reg_addr = 3'd3;
  endtask

  function automatic logic [31:0] pat(input int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic post(input int idx, input int n, input bit gat, input bit sw, input int t,
                      input int low, input bit expect_ok);
    int b = bufptr;
    int nb = (n + 3) / 4;
    bufptr += nb * 4 + 8;
    mem[(BASE + idx * 8) / 4]     = 32'(b | low);
    mem[(BASE + idx * 8) / 4 + 1] = {12'(t), 2'b00, sw, gat, 16'(n)};
    for (int k = 0; k < nb; k++) begin
      logic [31:0] w;
      int rem;
      w = pat(b + 4 * k);
      mem[b / 4 + k] = w;
      if (sw || ring_swap_b) w = {w[7:0], w[15:8], w[23:16], w[31:24]};
      rem = n - 4 * k;
      if (expect_ok)
        exp_q.push_back({rem <= 4, 12'(t), (rem <= 4) && !gat,
                         rem >= 4 ? 4'hF : 4'((1 << rem) - 1), w});
    end
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin @(negedge clk); n++; end
    chk(exp_q.size() == 0, "R4 all beats delivered", exp_q.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    mon_en = 0; rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(!tvalid && !mem_req && !done && !err, "R1 outputs in reset",
        {tvalid, mem_req, done, err}, 0);
    rst_ni = 1'b1; rd_exp = 0; ring_sz = 256;
    @(negedge clk); mon_en = 1;
  endtask

  task automatic config_ring();
    wreg(3'd0, BASE);
    wreg(3'd1, 8);
    ring_sz = 8;
    wreg(3'd4, MAXL);
  endtask

  initial begin
    logic [31:0] v;
    int ds;
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    do_reset();
    rreg(3'd3, v); chk(v == 0, "R1 read index after reset", v, 0);
    rreg(3'd2, v); chk(v == 0, "R1 write index after reset", v, 0);
    config_ring();

    // single descriptor, start timing and fetch address
    post(0, 10, 0, 0, 5, 0, 1);
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 1;
    @(negedge clk); reg_we = 1'b0; reg_addr = 3'd3;
    chk(!mem_req, "R2 no request in cycle after publish", mem_req, 0);
    @(negedge clk);
    chk(mem_req, "R2 request in second cycle", mem_req, 1);
    chk(mem_addr == BASE, "R3 descriptor address", mem_addr, BASE);
    drain();
    rreg(3'd3, v); chk(v == 1, "R8 index after one descriptor", v, 1);
    repeat (3) begin
      @(negedge clk); chk(!mem_req && !tvalid, "R2 idle when indices equal", mem_req, 0);
    end

    // descriptor swap bit, unaligned buffer address
    post(1, 4, 0, 1, 6, 2, 1);
    wreg(3'd2, 2); drain();

    // ring-wide swap
    wreg(3'd4, MAXL | (1 << 16)); ring_swap_b = 1;
    post(2, 7, 0, 0, 7, 0, 1);
    wreg(3'd2, 3); drain();
    wreg(3'd4, MAXL); ring_swap_b = 0;

    // gather chain with backpressure and memory stalls
    rdy_mode = 1; stall_en = 1; ds = done_seen;
    post(3, 5, 1, 0, 1, 0, 1);
    post(4, 8, 1, 0, 2, 0, 1);
    post(5, 3, 0, 0, 9, 0, 1);
    wreg(3'd2, 6); drain();
    chk(done_seen == ds + 1, "R6 one completion per chain", done_seen - ds, 1);

    // wrap around the ring
    post(6, 12, 0, 1, 10, 0, 1);
    post(7, 1, 0, 0, 11, 0, 1);
    post(0, 16, 0, 0, 12, 0, 1);
    post(1, 6, 1, 0, 13, 0, 1);
    post(2, 9, 0, 0, 14, 0, 1);
    wreg(3'd2, 3); drain();
    rreg(3'd3, v); chk(v == 3, "R8 index wraps", v, 3);
    rdy_mode = 0; stall_en = 0;

    // write index masking, read index read-only
    wreg(3'd2, 3 + 8);
    rreg(3'd2, v); chk(v == 3, "R10 write index masked", v, 3);
    repeat (4) begin
      @(negedge clk); chk(!mem_req, "R10 masked write starts nothing", mem_req, 0);
    end
    wreg(3'd3, 6);
    rreg(3'd3, v); chk(v == 3, "R10 read index not writable", v, 3);

    // length equal to limit is accepted
    post(3, MAXL, 0, 0, 15, 0, 1);
    wreg(3'd2, 4); drain();

    // over-limit length halts
    post(4, MAXL + 1, 0, 0, 16, 0, 0);
    wreg(3'd2, 5);
    repeat (12) @(negedge clk);
    chk(err, "R9 error on oversize", err, 1);
    rreg(3'd3, v); chk(v == 4, "R9 index frozen on error", v, 4);
    rreg(3'd5, v); chk(v == 1, "R10 status halted bit", v, 1);

    // zero length after a fresh reset
    do_reset();
    chk(!err, "R1 error cleared by reset", err, 0);
    config_ring();
    post(0, 0, 0, 0, 3, 0, 0);
    wreg(3'd2, 1);
    repeat (12) @(negedge clk);
    chk(err && !tvalid, "R9 error on zero length", err, 1);
    rreg(3'd3, v); chk(v == 0, "R9 index frozen on zero length", v, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule